// File: doc/BRIEF.md
# Set/Clear GPIO Port with Optional Registers

This block is a bank of general-purpose I/O lines controlled through a small word-addressed register bus. One line corresponds to each register bit, with bit 0 controlling line 0, so the register width sets the line count. Every register that is present has the same width. The block holds an output-value register and a direction register. It drives both toward the pads as registered outputs. It also resynchronises the pad input levels so they can be read back.

Five register slots sit at consecutive word indices. Slot 0 holds the line level, slot 1 is write-one-to-raise, slot 2 is write-one-to-lower, slot 3 is the drive-direction slot (1 = output) and slot 4 is the sense-direction slot (1 = input). Build parameters leave out the raise, lower or either direction slot. The remaining slots then take over the missing duties. Further build parameters select big-endian byte order on the bus and an input-only variant that never drives any line.

Top module: `gpio_setclr_port`

## Requirements
- R1: Reset clears the output value and the read data. When at least one direction slot exists, or the build is input-only, every line is an input after reset (pad_oe all zero).
- R2: A read of slot 0 returns, for each line, the output value if the line is an output and otherwise the pad level. The pad level passes through a two-stage synchroniser first.
- R3: With raise and lower slots both present, writing slot 1 sets the output bits written as 1 and leaves the bits written as 0 unchanged.
- R4: Writing a 1 to a bit of slot 2 drives that line low. A 0 bit leaves the line unchanged.
- R5: Without a lower slot, a write to slot 1 loads the whole output value, so 0 bits drive lines low.
- R6: Without a raise slot, a write to slot 0 loads the output value. With a raise slot present, writes to slot 0 have no effect.
- R7: Writing slot 3 makes lines with a 1 outputs and lines with a 0 inputs. A read of slot 3 returns that direction.
- R8: Writing slot 4 makes lines with a 1 inputs and lines with a 0 outputs. A read of slot 4 returns the complement of the drive direction.
- R9: With neither direction slot present, every line is permanently an output (pad_oe all ones, also during reset).
- R10: An input-only build keeps pad_oe and pad_out at zero whatever is written. Slot 0 reads report the pad levels.
- R11: With the big-endian option, byte k of bus data maps to byte N-1-k of the register, for both writes and reads. This holds for 16 lines, for example: bus 0xF000 means register 0x00F0.
- R12: A read of an absent slot, or of an index 5 to 7, returns 0. A write to an absent slot has no effect.
- R13: A write takes effect on pad_out/pad_oe at the clock edge that accepts it. Read data appears after the edge that accepts the read and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word index of the slot |
| bus_wdata | input | LINES | Write data in bus byte order |
| bus_rdata | output | LINES | Registered read data in bus byte order |
| pad_in | input | LINES | Pad input levels (asynchronous) |
| pad_out | output | LINES | Output value toward the pads |
| pad_oe | output | LINES | Output enable per line, 1 = drive |

## Verification
The assertions assume that at most one slot is accessed per cycle and that the bus inputs are held at zero while reset is asserted. The stepwise checks on the output state assume that the write strobe is the only thing that changes it. The bench drives every bus access for one cycle from the falling clock edge. It leaves the bus idle between accesses and keeps the request low during each reset. It changes pad_in only at falling edges and waits past the synchroniser before it reads a level.

// File: rtl/gpio_sc_pkg.sv
package gpio_sc_pkg;
  // Word indices of the register slots (order is part of the bus map)
  localparam logic [2:0] IDX_LEVEL = 3'd0;
  localparam logic [2:0] IDX_RAISE = 3'd1;
  localparam logic [2:0] IDX_LOWER = 3'd2;
  localparam logic [2:0] IDX_DRIVE = 3'd3;
  localparam logic [2:0] IDX_SENSE = 3'd4;
  localparam int unsigned SLOT_BITS = 3;
endpackage

// File: rtl/gpio_sc_sync.sv
module gpio_sc_sync #(
  parameter int unsigned W      = 16,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= '0;
    else     chain[0] <= async_in;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[s] <= '0;
      else     chain[s] <= chain[s-1];
    end
  end

  assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/gpio_sc_lane_order.sv
module gpio_sc_lane_order #(
  parameter int unsigned W   = 16,
  parameter bit          BIG = 1'b0
) (
  input  logic [W-1:0] a,
  output logic [W-1:0] y
);
  localparam int unsigned NB = W / 8;

  if (BIG) begin : g_swap
    for (genvar b = 0; b < NB; b++) begin : g_byte
      assign y[8*b +: 8] = a[8*(NB-1-b) +: 8];
    end
  end else begin : g_pass
    assign y = a;
  end
endmodule

// File: rtl/gpio_sc_regs.sv
module gpio_sc_regs
  import gpio_sc_pkg::*;
#(
  parameter int unsigned W          = 16,
  parameter bit          HAS_SET    = 1'b1,
  parameter bit          HAS_CLR    = 1'b1,
  parameter bit          HAS_DIROUT = 1'b1,
  parameter bit          HAS_DIRIN  = 1'b1,
  parameter bit          INPUT_ONLY = 1'b0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [SLOT_BITS-1:0] wr_idx,
  input  logic [W-1:0]         wr_word,
  output logic [W-1:0]         out_q,
  output logic [W-1:0]         dir_q
);
  localparam bit ANY_DIR = HAS_DIROUT || HAS_DIRIN;
  localparam logic [W-1:0] DIR_RESET = (INPUT_ONLY || ANY_DIR) ? '0 : '1;
  localparam bit DRIVES = !INPUT_ONLY;

  logic hit_level, hit_raise, hit_lower, hit_drive, hit_sense;

  always_comb begin
    hit_level = wr_en && (wr_idx == IDX_LEVEL) && !HAS_SET;
    hit_raise = wr_en && (wr_idx == IDX_RAISE) && HAS_SET;
    hit_lower = wr_en && (wr_idx == IDX_LOWER) && HAS_CLR;
    hit_drive = wr_en && (wr_idx == IDX_DRIVE) && HAS_DIROUT;
    hit_sense = wr_en && (wr_idx == IDX_SENSE) && HAS_DIRIN;
  end

  // Output value: slots that exist share the duties of the ones left out
  always_ff @(posedge clk) begin
    if (rst) begin
      out_q <= '0;
    end else if (DRIVES) begin
      if (hit_level)      out_q <= wr_word;
      else if (hit_raise) out_q <= HAS_CLR ? (out_q | wr_word) : wr_word;
      else if (hit_lower) out_q <= out_q & ~wr_word;
    end
  end

  // Direction: one state, two views of opposite polarity
  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q <= DIR_RESET;
    end else if (DRIVES) begin
      if (hit_drive)      dir_q <= wr_word;
      else if (hit_sense) dir_q <= ~wr_word;
    end
  end

  a_r13_idle_holds: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> ($stable(out_q) && $stable(dir_q)));

  a_r3_raise_keeps: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_idx == IDX_RAISE && HAS_SET && HAS_CLR && DRIVES)
    |=> (((out_q & $past(out_q)) == $past(out_q)) &&
         ((out_q & $past(wr_word)) == $past(wr_word))));

  a_r4_lower_clears: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_idx == IDX_LOWER && HAS_CLR && DRIVES)
    |=> ((out_q & $past(wr_word)) == '0));

  a_r8_sense_inverts: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_idx == IDX_SENSE && HAS_DIRIN && DRIVES)
    |=> (dir_q == ~$past(wr_word)));

  a_r10_input_only_quiet: assert property (@(posedge clk) disable iff (rst)
    !DRIVES |-> (out_q == '0 && dir_q == '0));
endmodule

// File: rtl/gpio_sc_readback.sv
module gpio_sc_readback
  import gpio_sc_pkg::*;
#(
  parameter int unsigned W          = 16,
  parameter bit          HAS_SET    = 1'b1,
  parameter bit          HAS_CLR    = 1'b1,
  parameter bit          HAS_DIROUT = 1'b1,
  parameter bit          HAS_DIRIN  = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 rd_en,
  input  logic                 rd_in_window,
  input  logic [SLOT_BITS-1:0] rd_idx,
  input  logic [W-1:0]         out_q,
  input  logic [W-1:0]         dir_q,
  input  logic [W-1:0]         level_in,
  output logic [W-1:0]         rdata_q
);
  logic [W-1:0] pick;

  always_comb begin
    pick = '0;
    if (rd_in_window) begin
      unique case (rd_idx)
        IDX_LEVEL: pick = (dir_q & out_q) | (~dir_q & level_in);
        IDX_RAISE: pick = HAS_SET    ? out_q  : '0;
        IDX_LOWER: pick = HAS_CLR    ? out_q  : '0;
        IDX_DRIVE: pick = HAS_DIROUT ? dir_q  : '0;
        IDX_SENSE: pick = HAS_DIRIN  ? ~dir_q : '0;
        default:   pick = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata_q <= '0;
    else if (rd_en) rdata_q <= pick;
  end

  a_r13_read_holds: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata_q));
endmodule

// File: rtl/gpio_setclr_port.sv
module gpio_setclr_port
  import gpio_sc_pkg::*;
#(
  parameter int unsigned LINES      = 16,
  parameter int unsigned ADDR_W     = 3,
  parameter int unsigned SYNC_DEPTH = 2,
  parameter bit          HAS_SET    = 1'b1,
  parameter bit          HAS_CLR    = 1'b1,
  parameter bit          HAS_DIROUT = 1'b1,
  parameter bit          HAS_DIRIN  = 1'b1,
  parameter bit          INPUT_ONLY = 1'b0,
  parameter bit          BIG_ENDIAN = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [LINES-1:0]  bus_wdata,
  output logic [LINES-1:0]  bus_rdata,
  input  logic [LINES-1:0]  pad_in,
  output logic [LINES-1:0]  pad_out,
  output logic [LINES-1:0]  pad_oe
);
  localparam logic [7:0] PRESENT = {3'b000, HAS_DIRIN, HAS_DIROUT, HAS_CLR, HAS_SET, 1'b1};

  logic                 wr_en, rd_en, in_window;
  logic [SLOT_BITS-1:0] idx;
  logic [LINES-1:0]     wr_native, rd_native, level_sync, out_q, dir_q;

  always_comb begin
    idx       = bus_addr[SLOT_BITS-1:0];
    in_window = (bus_addr >> SLOT_BITS) == '0;
    wr_en     = bus_sel && bus_wr && in_window;
    rd_en     = bus_sel && !bus_wr;
  end

  gpio_sc_lane_order #(.W(LINES), .BIG(BIG_ENDIAN)) u_wr_order (
    .a(bus_wdata), .y(wr_native));

  gpio_sc_sync #(.W(LINES), .STAGES(SYNC_DEPTH)) u_sync (
    .clk(clk), .rst(rst), .async_in(pad_in), .sync_out(level_sync));

  gpio_sc_regs #(
    .W(LINES), .HAS_SET(HAS_SET), .HAS_CLR(HAS_CLR),
    .HAS_DIROUT(HAS_DIROUT), .HAS_DIRIN(HAS_DIRIN), .INPUT_ONLY(INPUT_ONLY)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(idx), .wr_word(wr_native),
    .out_q(out_q), .dir_q(dir_q));

  gpio_sc_readback #(
    .W(LINES), .HAS_SET(HAS_SET), .HAS_CLR(HAS_CLR),
    .HAS_DIROUT(HAS_DIROUT), .HAS_DIRIN(HAS_DIRIN)
  ) u_read (
    .clk(clk), .rst(rst), .rd_en(rd_en), .rd_in_window(in_window), .rd_idx(idx),
    .out_q(out_q), .dir_q(dir_q), .level_in(level_sync), .rdata_q(rd_native));

  gpio_sc_lane_order #(.W(LINES), .BIG(BIG_ENDIAN)) u_rd_order (
    .a(rd_native), .y(bus_rdata));

  assign pad_out = out_q;
  assign pad_oe  = dir_q;

  a_r12_absent_reads_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_en && (!in_window || !PRESENT[idx])) |=> (bus_rdata == '0));

  a_r12_absent_write_ignored: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !PRESENT[idx]) |=> ($stable(pad_out) && $stable(pad_oe)));

  a_r10_no_drive_pins: assert property (@(posedge clk) disable iff (rst)
    INPUT_ONLY |-> (pad_oe == '0 && pad_out == '0));
endmodule

// File: tb/test_gpio_setclr_port.sv
module test_gpio_setclr_port;
  localparam int LINES = 16;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             bus_sel = 1'b0, bus_wr = 1'b0;
  logic [2:0]       bus_addr = '0;
  logic [LINES-1:0] bus_wdata = '0, pad_in = '0;
  logic [LINES-1:0] rd_a, out_a, oe_a, rd_b, out_b, oe_b;
  logic [LINES-1:0] rd_c, out_c, oe_c, rd_d, out_d, oe_d;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  // A: all slots, little-endian
  gpio_setclr_port i_gpio_setclr_port (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rd_a), .pad_in(pad_in), .pad_out(out_a), .pad_oe(oe_a));
  // B: no lower slot, no drive-direction slot, big-endian
  gpio_setclr_port #(.HAS_CLR(1'b0), .HAS_DIROUT(1'b0), .BIG_ENDIAN(1'b1)) i_gpio_setclr_port_b (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rd_b), .pad_in(pad_in), .pad_out(out_b), .pad_oe(oe_b));
  // C: level slot only
  gpio_setclr_port #(.HAS_SET(1'b0), .HAS_CLR(1'b0), .HAS_DIROUT(1'b0), .HAS_DIRIN(1'b0)) i_gpio_setclr_port_c (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rd_c), .pad_in(pad_in), .pad_out(out_c), .pad_oe(oe_c));
  // D: input-only
  gpio_setclr_port #(.INPUT_ONLY(1'b1)) i_gpio_setclr_port_d (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rd_d), .pad_in(pad_in), .pad_out(out_d), .pad_oe(oe_d));

  task automatic chk(input string req, input logic [LINES-1:0] act, input logic [LINES-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [LINES-1:0] swp(input logic [LINES-1:0] v);
    return {v[7:0], v[15:8]};
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [LINES-1:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic bus_read(input logic [2:0] a);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic t_reset();
    pad_in = 16'hBEEF;
    do_reset();
    chk("R1 out after reset", out_a, 16'h0000);
    chk("R1 oe after reset", oe_a, 16'h0000);
    chk("R1 rdata after reset", rd_a, 16'h0000);
    chk("R9 no-dir oe after reset", oe_c, 16'hFFFF);
    pad_in = '0;
  endtask

  task automatic t_raise_lower();
    do_reset();
    bus_write(3'd3, 16'hFFFF);
    chk("R7 drive slot sets oe", oe_a, 16'hFFFF);
    bus_write(3'd1, 16'h00F0);
    chk("R13 raise visible at write edge", out_a, 16'h00F0);
    bus_write(3'd1, 16'h0F00);
    chk("R3 raise keeps zero bits", out_a, 16'h0FF0);
    bus_write(3'd2, 16'h0030);
    chk("R4 lower clears ones", out_a, 16'h0FC0);
    bus_write(3'd0, 16'hFFFF);
    chk("R6 level write ignored with raise slot", out_a, 16'h0FC0);
    bus_read(3'd0);
    chk("R2 level read of outputs", rd_a, 16'h0FC0);
    repeat (3) @(negedge clk);
    chk("R13 read data holds", rd_a, 16'h0FC0);
    bus_read(3'd3);
    chk("R7 drive slot readback", rd_a, 16'hFFFF);
  endtask

  task automatic t_sense();
    do_reset();
    pad_in = 16'h1234;
    bus_write(3'd4, 16'h00FF);
    chk("R8 sense slot polarity", oe_a, 16'hFF00);
    repeat (3) @(negedge clk);
    bus_read(3'd4);
    chk("R8 sense slot readback", rd_a, 16'h00FF);
    bus_read(3'd3);
    chk("R7 drive view of sense write", rd_a, 16'hFF00);
    bus_read(3'd0);
    chk("R2 level read mixes pads and outputs", rd_a, 16'h0034);
    pad_in = '0;
  endtask

  task automatic t_noclr_big();
    do_reset();
    pad_in = 16'h0001;
    bus_write(3'd1, swp(16'h00F0));
    chk("R11 big-endian write", out_b, 16'h00F0);
    bus_write(3'd1, swp(16'h0003));
    chk("R5 raise loads without lower slot", out_b, 16'h0003);
    bus_write(3'd4, swp(16'hFF0F));
    chk("R8 sense slot on B", oe_b, 16'h00F0);
    repeat (3) @(negedge clk);
    bus_read(3'd0);
    chk("R11 big-endian read", rd_b, swp(16'h0001));
    bus_write(3'd2, swp(16'h0003));
    chk("R12 write to absent lower slot ignored", out_b, 16'h0003);
    bus_read(3'd2);
    chk("R12 absent lower slot reads 0", rd_b, 16'h0000);
    bus_read(3'd3);
    chk("R12 absent drive slot reads 0", rd_b, 16'h0000);
    pad_in = '0;
  endtask

  task automatic t_level_only();
    do_reset();
    bus_write(3'd0, 16'hA5A5);
    chk("R6 level write loads without raise slot", out_c, 16'hA5A5);
    chk("R9 no-dir oe stays high", oe_c, 16'hFFFF);
    bus_write(3'd1, 16'h00FF);
    chk("R12 write to absent raise slot ignored", out_c, 16'hA5A5);
    bus_read(3'd0);
    chk("R2 level read on C", rd_c, 16'hA5A5);
    bus_read(3'd1);
    chk("R12 absent raise slot reads 0", rd_c, 16'h0000);
    bus_read(3'd7);
    chk("R12 index 7 reads 0", rd_a, 16'h0000);
  endtask

  task automatic t_input_only();
    do_reset();
    pad_in = 16'h5A5A;
    bus_write(3'd3, 16'hFFFF);
    bus_write(3'd1, 16'hFFFF);
    bus_write(3'd0, 16'hFFFF);
    chk("R10 input-only oe", oe_d, 16'h0000);
    chk("R10 input-only out", out_d, 16'h0000);
    bus_read(3'd0);
    chk("R10 input-only reads pads", rd_d, 16'h5A5A);
    pad_in = '0;
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    t_reset();
    t_raise_lower();
    t_sense();
    t_noclr_big();
    t_level_only();
    t_input_only();
    repeat (2) @(negedge clk);
    finish_up();
  end
endmodule